// File: doc/BRIEF.md
# Tracking-Box Overlay Encoder

This block sits between a raster RGB pixel source and a YUV byte sink in a visual tracking pipeline. Pixels arrive one at a time in raster order together with the current tracked centre. As each pixel streams through, the block works out its own column and row from a running counter. It decides from coordinate comparisons alone whether the pixel lies on the one-pixel border of a fixed-size tracking rectangle centred on the tracked position. Border pixels are replaced with pure red. No frame is ever stored.

Each surviving pixel is then converted to full-range YUV with fixed-point coefficients and emitted as three consecutive bytes (Y, then U, then V) on a single byte-wide output. Because one pixel becomes three bytes, the block accepts at most one pixel every three cycles and tells the source so through a ready output. The centre is captured once per frame, on the frame's first pixel, so the rectangle never tears partway down a frame.

Top module: `tbox_encoder`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` is 0 and `pix_ready` is 1.
- R2: Every accepted pixel produces exactly three output bytes on consecutive cycles, tagged by `out_chan` as 0 (Y), then 1 (U), then 2 (V), in acceptance order.
- R3: When a pixel is accepted while the block is empty (no output byte in that cycle and no acceptance in the previous cycle), its Y byte appears on the output two clock edges after the accepting edge.
- R4: A pixel is accepted on a rising edge where `pix_valid` and `pix_ready` are both 1; with `pix_valid` held high the block sustains one acceptance every three cycles, and `pix_ready` is 0 only while output bytes are still being sent.
- R5: An accepted pixel with `pix_sof`=1 is at column 0, row 0; later pixels advance the column, wrapping from 175 to 0 with the row advancing, and after row 143 column 175 the next pixel is column 0, row 0 of a new frame.
- R6: With latched centre (cx, cy), the box spans columns cx-10 to cx+9 and rows cy-13 to cy+12; a pixel on its left or right column within the row span, or on its top or bottom row within the column span, is replaced by R=255, G=0, B=0 before conversion.
- R7: Pixels not on the box border are converted unchanged.
- R8: Box edges that fall outside the frame are simply not drawn; they never wrap to the opposite side or move to the frame edge.
- R9: The centre inputs are sampled only with the pixel at column 0, row 0; changes at any other time take effect from the next frame.
- R10: Y=(77R+150G+29B+128)>>8, U=((-43R-85G+128B+128)>>8)+128, V=((128R-107G-21B+128)>>8)+128, with arithmetic shift and each result clamped to 0..255.
- R11: `out_sof` is 1 exactly on the Y byte of a pixel at column 0, row 0.
- R12: `pix_valid` while `pix_ready` is 0 is ignored: the offered pixel yields no output bytes and does not advance the coordinates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_valid | input | 1 | Input pixel offered |
| pix_sof | input | 1 | Offered pixel is the first of a frame |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| ctr_x | input | XW (8) | Tracked centre column |
| ctr_y | input | YW (8) | Tracked centre row |
| pix_ready | output | 1 | Block can accept a pixel this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_chan | output | 2 | Channel of output byte: 0 Y, 1 U, 2 V |
| out_sof | output | 1 | Y byte of the first pixel of a frame |

## Verification
A wrong coordinate counter or a stale centre shows up as red bytes (Y=77, U=85, V=255) at the wrong place in the byte stream, or as missing ones, within the first row that crosses the box; the bench compares every byte against a model so the first misplaced border pixel is reported. A wrong serializer state shows at once as a channel tag out of order or as a missing or extra byte. Long runs cover frame wrap, edge clipping on all four sides and a centre changed mid-frame.

// File: rtl/tbox_pkg.sv
package tbox_pkg;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    typedef struct packed {
        logic [7:0] y;
        logic [7:0] u;
        logic [7:0] v;
    } yuv_t;

    typedef enum logic [1:0] {
        SER_IDLE = 2'd0,
        SER_Y    = 2'd1,
        SER_U    = 2'd2,
        SER_V    = 2'd3
    } ser_state_e;

    localparam logic [1:0] CHAN_Y = 2'd0;
    localparam logic [1:0] CHAN_U = 2'd1;
    localparam logic [1:0] CHAN_V = 2'd2;

    // fixed-point colour coefficients, scale 256
    localparam int KY_R = 77;
    localparam int KY_G = 150;
    localparam int KY_B = 29;
    localparam int KU_R = -43;
    localparam int KU_G = -85;
    localparam int KU_B = 128;
    localparam int KV_R = 128;
    localparam int KV_G = -107;
    localparam int KV_B = -21;
    localparam int FRAC_BITS  = 8;
    localparam int ROUND_ADD  = 128;
    localparam int CHROMA_OFS = 128;

    localparam rgb_t MARK_COLOUR = '{r: 8'd255, g: 8'd0, b: 8'd0};

endpackage

// File: rtl/tbox_marker.sv
module tbox_marker
    import tbox_pkg::*;
#(
    parameter int FRAME_W = 176,
    parameter int FRAME_H = 144,
    parameter int BOX_W   = 20,
    parameter int BOX_H   = 26,
    parameter int XW      = 8,
    parameter int YW      = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          drain,
    input  logic          pix_sof,
    input  rgb_t          pix_in,
    input  logic [XW-1:0] ctr_x,
    input  logic [YW-1:0] ctr_y,
    output logic          mk_valid,
    output logic          mk_first,
    output rgb_t          mk_pix
);

    localparam int SW = ((XW > YW) ? XW : YW) + 2;
    localparam logic signed [SW-1:0] HALF_W = SW'(BOX_W / 2);
    localparam logic signed [SW-1:0] HALF_H = SW'(BOX_H / 2);
    localparam logic signed [SW-1:0] SPAN_W = SW'(BOX_W - 1);
    localparam logic signed [SW-1:0] SPAN_H = SW'(BOX_H - 1);
    localparam logic [XW-1:0] LAST_X = XW'(FRAME_W - 1);
    localparam logic [YW-1:0] LAST_Y = YW'(FRAME_H - 1);

    typedef struct packed {
        logic [XW-1:0] pos_x;
        logic [YW-1:0] pos_y;
        logic [XW-1:0] lat_x;
        logic [YW-1:0] lat_y;
        logic          vld;
        logic          first;
        rgb_t          pix;
    } mk_state_t;

    mk_state_t s_d, s_q;

    logic [XW-1:0] cur_x;
    logic [YW-1:0] cur_y;
    logic          frame_start;
    logic [XW-1:0] eff_cx;
    logic [YW-1:0] eff_cy;
    logic signed [SW-1:0] sx, sy, edge_l, edge_r, edge_t, edge_b;
    logic          in_cols, in_rows, on_vert, on_horz, on_box;

    always_comb begin
        cur_x       = pix_sof ? '0 : s_q.pos_x;
        cur_y       = pix_sof ? '0 : s_q.pos_y;
        frame_start = (cur_x == '0) && (cur_y == '0);
        eff_cx      = frame_start ? ctr_x : s_q.lat_x;
        eff_cy      = frame_start ? ctr_y : s_q.lat_y;

        sx     = signed'(SW'(cur_x));
        sy     = signed'(SW'(cur_y));
        edge_l = signed'(SW'(eff_cx)) - HALF_W;
        edge_r = edge_l + SPAN_W;
        edge_t = signed'(SW'(eff_cy)) - HALF_H;
        edge_b = edge_t + SPAN_H;

        in_cols = (sx >= edge_l) && (sx <= edge_r);
        in_rows = (sy >= edge_t) && (sy <= edge_b);
        on_vert = ((sx == edge_l) || (sx == edge_r)) && in_rows;
        on_horz = ((sy == edge_t) || (sy == edge_b)) && in_cols;
        on_box  = on_vert || on_horz;

        s_d = s_q;
        if (accept) begin
            s_d.vld   = 1'b1;
            s_d.first = frame_start;
            s_d.pix   = on_box ? MARK_COLOUR : pix_in;
            if (frame_start) begin
                s_d.lat_x = ctr_x;
                s_d.lat_y = ctr_y;
            end
            if (cur_x == LAST_X) begin
                s_d.pos_x = '0;
                s_d.pos_y = (cur_y == LAST_Y) ? '0 : cur_y + YW'(1);
            end else begin
                s_d.pos_x = cur_x + XW'(1);
                s_d.pos_y = cur_y;
            end
        end else if (drain) begin
            s_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mk_valid = s_q.vld;
    assign mk_first = s_q.first;
    assign mk_pix   = s_q.pix;

endmodule

// File: rtl/tbox_rgb2yuv.sv
module tbox_rgb2yuv
    import tbox_pkg::*;
(
    input  rgb_t px,
    output yuv_t yc
);

    function automatic logic [7:0] sat8(input int v);
        if (v < 0) begin
            return 8'd0;
        end else if (v > 255) begin
            return 8'd255;
        end
        return 8'(v);
    endfunction

    always_comb begin
        int ri, gi, bi, acc_y, acc_u, acc_v;
        ri = int'(px.r);
        gi = int'(px.g);
        bi = int'(px.b);
        acc_y = KY_R * ri + KY_G * gi + KY_B * bi + ROUND_ADD;
        acc_u = KU_R * ri + KU_G * gi + KU_B * bi + ROUND_ADD;
        acc_v = KV_R * ri + KV_G * gi + KV_B * bi + ROUND_ADD;
        yc.y = sat8(acc_y >>> FRAC_BITS);
        yc.u = sat8((acc_u >>> FRAC_BITS) + CHROMA_OFS);
        yc.v = sat8((acc_v >>> FRAC_BITS) + CHROMA_OFS);
    end

endmodule

// File: rtl/tbox_serializer.sv
module tbox_serializer
    import tbox_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_first,
    input  yuv_t       in_yuv,
    output logic       can_load,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic [1:0] out_chan,
    output logic       out_sof
);

    typedef struct packed {
        ser_state_e st;
        yuv_t       held;
        logic       first;
    } ser_t;

    ser_t s_d, s_q;
    logic load;

    always_comb begin
        can_load = (s_q.st == SER_IDLE) || (s_q.st == SER_V);
        load     = in_valid && can_load;

        s_d = s_q;
        unique case (s_q.st)
            SER_IDLE: s_d.st = load ? SER_Y : SER_IDLE;
            SER_Y:    s_d.st = SER_U;
            SER_U:    s_d.st = SER_V;
            SER_V:    s_d.st = load ? SER_Y : SER_IDLE;
            default:  s_d.st = SER_IDLE;
        endcase
        if (load) begin
            s_d.held  = in_yuv;
            s_d.first = in_first;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        out_valid = (s_q.st != SER_IDLE);
        out_sof   = s_q.first && (s_q.st == SER_Y);
        unique case (s_q.st)
            SER_Y: begin
                out_data = s_q.held.y;
                out_chan = CHAN_Y;
            end
            SER_U: begin
                out_data = s_q.held.u;
                out_chan = CHAN_U;
            end
            SER_V: begin
                out_data = s_q.held.v;
                out_chan = CHAN_V;
            end
            default: begin
                out_data = 8'd0;
                out_chan = CHAN_Y;
            end
        endcase
    end

endmodule

// File: rtl/tbox_encoder.sv
module tbox_encoder
    import tbox_pkg::*;
#(
    parameter int FRAME_W = 176,
    parameter int FRAME_H = 144,
    parameter int BOX_W   = 20,
    parameter int BOX_H   = 26,
    localparam int XW     = $clog2(FRAME_W),
    localparam int YW     = $clog2(FRAME_H)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_valid,
    input  logic          pix_sof,
    input  logic [7:0]    pix_r,
    input  logic [7:0]    pix_g,
    input  logic [7:0]    pix_b,
    input  logic [XW-1:0] ctr_x,
    input  logic [YW-1:0] ctr_y,
    output logic          pix_ready,
    output logic          out_valid,
    output logic [7:0]    out_data,
    output logic [1:0]    out_chan,
    output logic          out_sof
);

    logic mk_valid, mk_first, ser_can_load, accept, drain;
    rgb_t pix_in, mk_pix;
    yuv_t mk_yuv;

    always_comb begin
        pix_in    = '{r: pix_r, g: pix_g, b: pix_b};
        pix_ready = !mk_valid || ser_can_load;
        accept    = pix_valid && pix_ready;
        drain     = mk_valid && ser_can_load;
    end

    tbox_marker #(
        .FRAME_W(FRAME_W), .FRAME_H(FRAME_H),
        .BOX_W(BOX_W), .BOX_H(BOX_H), .XW(XW), .YW(YW)
    ) u_marker (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .drain    (drain),
        .pix_sof  (pix_sof),
        .pix_in   (pix_in),
        .ctr_x    (ctr_x),
        .ctr_y    (ctr_y),
        .mk_valid (mk_valid),
        .mk_first (mk_first),
        .mk_pix   (mk_pix)
    );

    tbox_rgb2yuv u_conv (
        .px (mk_pix),
        .yc (mk_yuv)
    );

    tbox_serializer u_ser (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (mk_valid),
        .in_first  (mk_first),
        .in_yuv    (mk_yuv),
        .can_load  (ser_can_load),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_chan  (out_chan),
        .out_sof   (out_sof)
    );

endmodule

// File: rtl/tbox_checker.sv
module tbox_checker (
    input logic       clk,
    input logic       rst,
    input logic       pix_valid,
    input logic       pix_ready,
    input logic       out_valid,
    input logic [1:0] out_chan,
    input logic       out_sof
);

    logic acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= 1'b0;
        end else begin
            acc_q <= pix_valid && pix_ready;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && pix_ready));

    assert_y_then_u_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_chan == 2'd0) |=> (out_valid && out_chan == 2'd1));

    assert_u_then_v_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_chan == 2'd1) |=> (out_valid && out_chan == 2'd2));

    assert_first_byte_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_ready && !out_valid && !acc_q) |=> ##1 (out_valid && out_chan == 2'd0));

    assert_stall_only_busy_R4: assert property (@(posedge clk) disable iff (rst)
        !pix_ready |-> out_valid);

    assert_sof_on_y_R11: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> (out_valid && out_chan == 2'd0));

endmodule

bind tbox_encoder tbox_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_sof   (out_sof)
);

// File: tb/sim_tbox_encoder.sv
`timescale 1ns/1ps
module sim_tbox_encoder;

    localparam int FW = 176;
    localparam int FH = 144;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_valid = 1'b0;
    logic       pix_sof = 1'b0;
    logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic [7:0] ctr_x = '0, ctr_y = '0;
    logic       pix_ready, out_valid, out_sof;
    logic [7:0] out_data;
    logic [1:0] out_chan;

    always #4 clk = ~clk;

    tbox_encoder u0 (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_sof(pix_sof),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .ctr_x(ctr_x), .ctr_y(ctr_y), .pix_ready(pix_ready),
        .out_valid(out_valid), .out_data(out_data),
        .out_chan(out_chan), .out_sof(out_sof)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // expected stream: {sof, chan, data}
    logic [10:0] exp_q[$];
    string       tag_q[$];

    int m_x = 0, m_y = 0, m_cx = 0, m_cy = 0;
    int acc_total = 0, bytes_seen = 0;
    int cyc = 0, last_acc = -1, lat_due = 0;
    bit prev_acc = 0;
    string phase = "";

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clamp8(input int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction

    task automatic model_accept(input bit sof, input int r, input int g, input int b,
                                input int cx_in, input int cy_in);
        int x, y, l, rr, t, bt, yy, uu, vv;
        bit border;
        string t_pix;
        x = sof ? 0 : m_x;
        y = sof ? 0 : m_y;
        if (x == 0 && y == 0) begin
            m_cx = cx_in;
            m_cy = cy_in;
        end
        l = m_cx - 10; rr = m_cx + 9; t = m_cy - 13; bt = m_cy + 12;
        border = (((x == l) || (x == rr)) && y >= t && y <= bt) ||
                 (((y == t) || (y == bt)) && x >= l && x <= rr);
        if (border) begin
            r = 255; g = 0; b = 0;
            t_pix = "R6";
        end else begin
            t_pix = "R7 R10";
        end
        yy = clamp8((77*r + 150*g + 29*b + 128) >>> 8);
        uu = clamp8(((-43*r - 85*g + 128*b + 128) >>> 8) + 128);
        vv = clamp8(((128*r - 107*g - 21*b + 128) >>> 8) + 128);
        exp_q.push_back({(x == 0 && y == 0), 2'd0, 8'(yy)});
        exp_q.push_back({1'b0, 2'd1, 8'(uu)});
        exp_q.push_back({1'b0, 2'd2, 8'(vv)});
        for (int k = 0; k < 3; k++) tag_q.push_back({phase, " ", t_pix});
        if (x == FW - 1) begin
            m_x = 0;
            m_y = (y == FH - 1) ? 0 : y + 1;
        end else begin
            m_x = x + 1;
            m_y = y;
        end
    endtask

    // one cycle: check outputs, then drive inputs
    task automatic step(input bit v, input bit sof, input bit sustained, output bit took);
        logic [10:0] e;
        string tg;
        @(negedge clk);
        cyc++;
        if (lat_due > 0) begin
            lat_due--;
            if (lat_due == 0)
                check(out_valid && out_chan == 2'd0, "R3 first byte latency",
                      {30'd0, out_valid}, 1);
        end
        if (out_valid) begin
            bytes_seen++;
            if (exp_q.size() == 0) begin
                check(0, "R12 unexpected output byte", int'(out_data), -1);
            end else begin
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                check(out_data == e[7:0], {tg, " data"}, int'(out_data), int'(e[7:0]));
                check(out_chan == e[9:8], "R2 channel order", int'(out_chan), int'(e[9:8]));
                check(out_sof == e[10], "R11 frame start flag", int'(out_sof), int'(e[10]));
            end
        end
        pix_valid = v;
        pix_sof   = sof;
        pix_r = 8'($urandom); pix_g = 8'($urandom); pix_b = 8'($urandom);
        took = v && pix_ready;
        if (took) begin
            if (!out_valid && !prev_acc) lat_due = 2;
            if (sustained && last_acc >= 0)
                check(cyc - last_acc == 3, "R4 sustained acceptance interval",
                      cyc - last_acc, 3);
            last_acc = cyc;
            acc_total++;
            model_accept(sof, int'(pix_r), int'(pix_g), int'(pix_b), int'(ctr_x), int'(ctr_y));
        end
        prev_acc = took;
    endtask

    task automatic run_frame(input string ph, input int npix, input int cx0, input int cy0,
                             input int chg_at, input int cx1, input int cy1,
                             input bit sustained);
        int got;
        bit took, v;
        phase = ph;
        got = 0;
        last_acc = -1;
        while (got < npix) begin
            ctr_x = 8'((got >= chg_at) ? cx1 : cx0);
            ctr_y = 8'((got >= chg_at) ? cy1 : cy0);
            v = sustained ? 1'b1 : ($urandom_range(7) != 0);
            step(v, (got == 0), sustained, took);
            if (took) got++;
        end
    endtask

    initial begin
        bit took;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(!out_valid, "R1 out_valid in reset", {31'd0, out_valid}, 0);
        check(pix_ready, "R1 pix_ready in reset", {31'd0, pix_ready}, 1);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && pix_ready, "R1 state after reset",
              {30'd0, out_valid, pix_ready}, 1);

        // top-left clipping, random gaps (stalled offers carry junk: R12)
        run_frame("R8 R12", FW * 24, 2, 3, 1 << 30, 0, 0, 0);
        // centre changed mid-frame must not move the box
        run_frame("R9", FW * 24, 88, 20, 500, 30, 10, 0);
        // right-edge clipping
        run_frame("R8 right", FW * 24, 170, 10, 1 << 30, 0, 0, 0);
        // full frame, bottom clipping, then wrap into a new frame with new centre
        run_frame("R5 R8 R4", FW * FH + 200, 100, 135, FW * FH, 5, 1, 1);

        for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 1'b0, took);
        check(exp_q.size() == 0, "R2 all expected bytes emitted", exp_q.size(), 0);
        check(bytes_seen == 3 * acc_total, "R12 byte count per accepted pixel",
              bytes_seen, 3 * acc_total);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 195000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule